// File: doc/BRIEF.md
# SCSI Bus Line Controller with Register Access

This block sits between a processor's byte-wide register port and the control and data lines of a SCSI bus. Software writes four registers that decide which bus lines the block pulls. The registers are an output data latch, an initiator command byte, a mode byte and a target command byte. Software reads back those registers, the sampled bus lines and a status byte. A role bit in the mode byte chooses initiator or target. That role decides which lines reach the bus. The phase lines and REQ come from the target command byte only when the block is a target. ACK and ATN leave the block only when it is an initiator. RST, BSY and SEL follow the initiator command byte in either role.

A mode bit enables a simple DMA interlock in which the initiator answers each REQ with an ACK. When REQ is sampled high, a request flag is raised. A read of the data address returns the bus byte and converts that request into a pending acknowledge, which drives ACK. When the target drops REQ, the acknowledge is released. Every output is a logical active-high "assert this line" flag, formed as the OR of its sources.

The register port is a plain strobe interface and not a stream. A write takes effect at the clock edge where `reg_wr` is high, and the driven lines change from that edge. A read strobe produces `rd_valid` with `rd_data` exactly one cycle later. There is no back-pressure: every strobe is accepted in its own cycle.

Top module: `scsi_line_ctrl`

## Requirements
- R1: After reset, the data latch, initiator command, mode and target command registers all read 0xFF. With those values the block drives RST, BSY, SEL, REQ, MSG, C/D and I/O, and enables the data bus with 0xFF. ACK and ATN stay released.
- R2: Initiator command bits drive lines in both roles. Bit 7 drives RST, bit 3 drives BSY and bit 2 drives SEL. Bit 0 enables the data bus, which then carries the byte last written to address 0.
- R3: When mode bit 6 is 1 (target role), target command bit 3 drives REQ, bit 2 drives MSG, bit 1 drives C/D and bit 0 drives I/O. When mode bit 6 is 0, those four lines are released.
- R4: When mode bit 6 is 0 (initiator role), initiator command bit 4 drives ACK and bit 1 drives ATN. In target role, ACK and ATN are released whatever the command bits hold.
- R5: Reading address 1, 2 or 3 returns the stored initiator command, mode or target command byte. Address 3 returns the stored byte, not the bus lines.
- R6: Reading address 4 returns the sampled lines as REQ in bit 4, MSG in bit 3, C/D in bit 2, I/O in bit 1 and ACK in bit 0, with the upper bits 0.
- R7: Reading address 5 returns a status byte. Bit 3 is phase match: the target command's MSG, C/D and I/O bits equal the sampled MSG, C/D and I/O lines. Bit 6 is the DMA request flag and bit 0 is the DMA acknowledge flag; the other bits are 0.
- R8: With mode bit 1 set (DMA on), a sampled REQ high with no request and no acknowledge pending sets the request flag at the next edge. While an acknowledge is pending, REQ sets no new request.
- R9: Reading address 0 returns the sampled data bus. If DMA is on and a request is pending, that read clears the request and sets the acknowledge flag. ACK is then driven in initiator role from the next cycle. A data read with no request pending changes no flag.
- R10: While the acknowledge flag is set and REQ is sampled low, the flag clears at the next edge and ACK is released, unless initiator bit 4 holds it.
- R11: Clearing mode bit 1 clears both DMA flags at the edge after the mode change.
- R12: `rd_valid` rises exactly one cycle after a `reg_rd` strobe and is low otherwise. Addresses 6 and 7 read as 0. A write is visible on the lines and by read-back from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | 8 | Read data |
| bus_data_i | input | 8 | Sampled SCSI data bus |
| bus_req_i | input | 1 | Sampled REQ |
| bus_msg_i | input | 1 | Sampled MSG |
| bus_cd_i | input | 1 | Sampled C/D |
| bus_io_i | input | 1 | Sampled I/O |
| bus_ack_i | input | 1 | Sampled ACK |
| drv_data_o | output | 8 | Data to place on the bus |
| drv_data_en_o | output | 1 | Data bus drive enable |
| drv_rst_o | output | 1 | Assert RST |
| drv_bsy_o | output | 1 | Assert BSY |
| drv_sel_o | output | 1 | Assert SEL |
| drv_ack_o | output | 1 | Assert ACK |
| drv_atn_o | output | 1 | Assert ATN |
| drv_req_o | output | 1 | Assert REQ |
| drv_msg_o | output | 1 | Assert MSG |
| drv_cd_o | output | 1 | Assert C/D |
| drv_io_o | output | 1 | Assert I/O |

## Verification
The bench probes the role gate from both sides. It sets ACK and ATN bits, then switches to target role and expects both lines released. It loads a target command in initiator role and expects REQ and the phase lines to stay quiet; a design that ignored the role bit would leak these lines onto the bus. It reads address 3 with bus lines that differ from the stored byte, to catch a design that returns the bus state there. It runs a full DMA handshake. It checks that a second REQ during a pending acknowledge raises no new request, that a data read with nothing pending leaves ACK released, and that turning DMA off clears flags left from earlier. A wrong handshake would show up as ACK that sticks, arrives a cycle late, or answers a REQ that was never read.

// File: rtl/scsi_line_pkg.sv
package scsi_line_pkg;
  // register addresses
  localparam int unsigned AD_DATA   = 0;
  localparam int unsigned AD_ICMD   = 1;
  localparam int unsigned AD_MODE   = 2;
  localparam int unsigned AD_TCMD   = 3;
  localparam int unsigned AD_LINES  = 4;
  localparam int unsigned AD_STATUS = 5;

  // initiator command bit positions
  localparam int unsigned IC_RST = 7;
  localparam int unsigned IC_ACK = 4;
  localparam int unsigned IC_BSY = 3;
  localparam int unsigned IC_SEL = 2;
  localparam int unsigned IC_ATN = 1;
  localparam int unsigned IC_DEN = 0;

  // mode bit positions
  localparam int unsigned MD_TARGET = 6;
  localparam int unsigned MD_DMA    = 1;

  // target command bit positions
  localparam int unsigned TC_REQ = 3;
  localparam int unsigned TC_MSG = 2;
  localparam int unsigned TC_CD  = 1;
  localparam int unsigned TC_IO  = 0;

  typedef struct packed {
    logic rst;
    logic bsy;
    logic sel;
    logic ack;
    logic atn;
    logic req;
    logic msg;
    logic cd;
    logic io;
  } line_set_t;
endpackage

// File: rtl/scsi_line_regs.sv
module scsi_line_regs
  import scsi_line_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout_q,
  output logic [DW-1:0] icmd_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcmd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '1;
      icmd_q <= '1;
      mode_q <= '1;
      tcmd_q <= '1;
    end else if (wr) begin
      if (addr == AW'(AD_DATA)) dout_q <= wdata;
      if (addr == AW'(AD_ICMD)) icmd_q <= wdata;
      if (addr == AW'(AD_MODE)) mode_q <= wdata;
      if (addr == AW'(AD_TCMD)) tcmd_q <= wdata;
    end
  end

  assert_wr_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(AD_MODE)) |=> (mode_q == $past(wdata)));
endmodule

// File: rtl/scsi_line_dma.sv
module scsi_line_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_on,
  input  logic bus_req,
  input  logic data_rd,
  output logic req_f,
  output logic ack_f
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_f <= 1'b0;
      ack_f <= 1'b0;
    end else if (!dma_on) begin
      req_f <= 1'b0;
      ack_f <= 1'b0;
    end else if (req_f && data_rd) begin
      req_f <= 1'b0;
      ack_f <= 1'b1;
    end else if (ack_f && !bus_req) begin
      ack_f <= 1'b0;
    end else if (!req_f && !ack_f && bus_req) begin
      req_f <= 1'b1;
    end
  end

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_f && ack_f));
  assert_read_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && req_f && data_rd) |=> (ack_f && !req_f));
  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_f && !bus_req) |=> !ack_f);
  assert_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |=> (!req_f && !ack_f));
  assert_no_req_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_f && !data_rd) |=> !req_f);
endmodule

// File: rtl/scsi_line_drive.sv
module scsi_line_drive
  import scsi_line_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          target_role,
  input  logic          dma_on,
  input  logic          dma_ack,
  input  logic          ic_rst,
  input  logic          ic_ack,
  input  logic          ic_bsy,
  input  logic          ic_sel,
  input  logic          ic_atn,
  input  logic          ic_den,
  input  logic [3:0]    tc_bits,
  input  logic [DW-1:0] dout,
  output line_set_t     lines,
  output logic          data_en,
  output logic [DW-1:0] data
);
  always_comb begin
    lines     = '0;
    lines.rst = ic_rst;
    lines.bsy = ic_bsy;
    lines.sel = ic_sel;
    if (target_role) begin
      lines.req = tc_bits[TC_REQ];
      lines.msg = tc_bits[TC_MSG];
      lines.cd  = tc_bits[TC_CD];
      lines.io  = tc_bits[TC_IO];
    end else begin
      lines.ack = ic_ack | (dma_on & dma_ack);
      lines.atn = ic_atn;
    end
    data_en = ic_den;
    data    = dout;
  end
endmodule

// File: rtl/scsi_line_read.sv
module scsi_line_read
  import scsi_line_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] icmd,
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] tcmd,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_req,
  input  logic          bus_msg,
  input  logic          bus_cd,
  input  logic          bus_io,
  input  logic          bus_ack,
  input  logic          req_f,
  input  logic          ack_f,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mux_val;
  logic          phase_ok;

  assign phase_ok = ({tcmd[TC_MSG], tcmd[TC_CD], tcmd[TC_IO]} ==
                     {bus_msg, bus_cd, bus_io});

  always_comb begin
    mux_val = '0;
    unique case (addr)
      AW'(AD_DATA):  mux_val = bus_data;
      AW'(AD_ICMD):  mux_val = icmd;
      AW'(AD_MODE):  mux_val = mode;
      AW'(AD_TCMD):  mux_val = tcmd;
      AW'(AD_LINES): mux_val = DW'({bus_req, bus_msg, bus_cd, bus_io, bus_ack});
      AW'(AD_STATUS): begin
        mux_val[6] = req_f;
        mux_val[3] = phase_ok;
        mux_val[0] = ack_f;
      end
      default:       mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= mux_val;
    end
  end

  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rd_valid);
endmodule

// File: rtl/scsi_line_ctrl.sv
module scsi_line_ctrl
  import scsi_line_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_req_i,
  input  logic          bus_msg_i,
  input  logic          bus_cd_i,
  input  logic          bus_io_i,
  input  logic          bus_ack_i,
  output logic [DW-1:0] drv_data_o,
  output logic          drv_data_en_o,
  output logic          drv_rst_o,
  output logic          drv_bsy_o,
  output logic          drv_sel_o,
  output logic          drv_ack_o,
  output logic          drv_atn_o,
  output logic          drv_req_o,
  output logic          drv_msg_o,
  output logic          drv_cd_o,
  output logic          drv_io_o
);
  logic [DW-1:0] dout_q, icmd_q, mode_q, tcmd_q;
  logic          req_f, ack_f, data_rd, target_role, dma_on;
  line_set_t     lines;

  assign target_role = mode_q[MD_TARGET];
  assign dma_on      = mode_q[MD_DMA];
  assign data_rd     = reg_rd && (reg_addr == AW'(AD_DATA));

  scsi_line_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dout_q(dout_q), .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q)
  );

  scsi_line_dma u_dma (
    .clk(clk), .rst_n(rst_n), .dma_on(dma_on), .bus_req(bus_req_i),
    .data_rd(data_rd), .req_f(req_f), .ack_f(ack_f)
  );

  scsi_line_drive #(.DW(DW)) u_drive (
    .target_role(target_role), .dma_on(dma_on), .dma_ack(ack_f),
    .ic_rst(icmd_q[IC_RST]), .ic_ack(icmd_q[IC_ACK]), .ic_bsy(icmd_q[IC_BSY]),
    .ic_sel(icmd_q[IC_SEL]), .ic_atn(icmd_q[IC_ATN]), .ic_den(icmd_q[IC_DEN]),
    .tc_bits(tcmd_q[3:0]), .dout(dout_q),
    .lines(lines), .data_en(drv_data_en_o), .data(drv_data_o)
  );

  scsi_line_read #(.DW(DW), .AW(AW)) u_read (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
    .icmd(icmd_q), .mode(mode_q), .tcmd(tcmd_q),
    .bus_data(bus_data_i), .bus_req(bus_req_i), .bus_msg(bus_msg_i),
    .bus_cd(bus_cd_i), .bus_io(bus_io_i), .bus_ack(bus_ack_i),
    .req_f(req_f), .ack_f(ack_f), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign drv_rst_o = lines.rst;
  assign drv_bsy_o = lines.bsy;
  assign drv_sel_o = lines.sel;
  assign drv_ack_o = lines.ack;
  assign drv_atn_o = lines.atn;
  assign drv_req_o = lines.req;
  assign drv_msg_o = lines.msg;
  assign drv_cd_o  = lines.cd;
  assign drv_io_o  = lines.io;

  assert_target_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    target_role |-> (!drv_ack_o && !drv_atn_o));
  assert_init_no_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !target_role |-> !(drv_req_o || drv_msg_o || drv_cd_o || drv_io_o));
  assert_dma_ack_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!target_role && dma_on && ack_f) |-> drv_ack_o);
endmodule

// File: tb/sim_scsi_line_ctrl.sv
module sim_scsi_line_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] bus_data_i = '0;
  logic       bus_req_i = 1'b0, bus_msg_i = 1'b0, bus_cd_i = 1'b0;
  logic       bus_io_i = 1'b0, bus_ack_i = 1'b0;
  logic [7:0] drv_data_o;
  logic       drv_data_en_o, drv_rst_o, drv_bsy_o, drv_sel_o, drv_ack_o;
  logic       drv_atn_o, drv_req_o, drv_msg_o, drv_cd_o, drv_io_o;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  scsi_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_data_i(bus_data_i), .bus_req_i(bus_req_i),
    .bus_msg_i(bus_msg_i), .bus_cd_i(bus_cd_i), .bus_io_i(bus_io_i),
    .bus_ack_i(bus_ack_i), .drv_data_o(drv_data_o),
    .drv_data_en_o(drv_data_en_o), .drv_rst_o(drv_rst_o),
    .drv_bsy_o(drv_bsy_o), .drv_sel_o(drv_sel_o), .drv_ack_o(drv_ack_o),
    .drv_atn_o(drv_atn_o), .drv_req_o(drv_req_o), .drv_msg_o(drv_msg_o),
    .drv_cd_o(drv_cd_o), .drv_io_o(drv_io_o)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // line vector: rst bsy sel ack atn req msg cd io den
  function automatic logic [9:0] lines_now();
    return {drv_rst_o, drv_bsy_o, drv_sel_o, drv_ack_o, drv_atn_o,
            drv_req_o, drv_msg_o, drv_cd_o, drv_io_o, drv_data_en_o};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: pushes expected read value, monitor compares
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12: unexpected rd_valid got %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({8'h00, rd_data}, {8'h00, e}, t);
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check({6'b0, lines_now()}, {6'b0, 10'b1110011111}, "R1 reset lines");
    check({8'h00, drv_data_o}, 16'h00FF, "R1 reset data");
    rd(3'd1, 8'hFF, "R1 icmd reset");
    rd(3'd2, 8'hFF, "R1 mode reset");
    rd(3'd3, 8'hFF, "R1 tcmd reset");
    rd(3'd0, 8'h00, "R1 data read bus");
    tick();

    // R3/R4 initiator role
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h12);
    check({6'b0, lines_now()}, {6'b0, 10'b0001100000}, "R4 initiator ack+atn");
    wr(3'd3, 8'h0F);
    check({6'b0, lines_now()}, {6'b0, 10'b0001100000}, "R3 tcmd ignored in initiator");
    bus_req_i = 1'b0; bus_msg_i = 1'b1; bus_cd_i = 1'b0; bus_io_i = 1'b1;
    rd(3'd3, 8'h0F, "R5 tcmd stored not bus");
    rd(3'd1, 8'h12, "R5 icmd readback");
    rd(3'd6, 8'h00, "R12 addr6 zero");
    rd(3'd7, 8'h00, "R12 addr7 zero");

    // target role
    wr(3'd2, 8'h40);
    check({6'b0, lines_now()}, {6'b0, 10'b0000011110}, "R4 target releases ack/atn");
    wr(3'd3, 8'h05);
    check({6'b0, lines_now()}, {6'b0, 10'b0000001010}, "R3 target drives msg io");
    rd(3'd2, 8'h40, "R5 mode readback");

    // R7 phase match
    rd(3'd5, 8'h08, "R7 phase match");
    bus_cd_i = 1'b1;
    rd(3'd5, 8'h00, "R7 phase mismatch");
    // R6 sampled lines
    bus_req_i = 1'b1; bus_ack_i = 1'b1; bus_msg_i = 1'b0;
    rd(3'd4, 8'h17, "R6 line readback");
    bus_req_i = 1'b0; bus_ack_i = 1'b0;
    bus_msg_i = 1'b0; bus_cd_i = 1'b0; bus_io_i = 1'b0;

    // R2 initiator lines and data
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'h8D);
    check({6'b0, lines_now()}, {6'b0, 10'b1110001011}, "R2 rst bsy sel den");
    check({8'h00, drv_data_o}, 16'h00A5, "R2 data latch");
    wr(3'd1, 8'h00);
    check({6'b0, lines_now()}, {6'b0, 10'b0000001010}, "R2 all released");

    // DMA handshake in initiator role
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h02);
    bus_req_i = 1'b1;
    tick();
    rd(3'd5, 8'h48, "R8 request flag set");
    check({15'b0, drv_ack_o}, 16'h0000, "R8 no ack before read");
    bus_data_i = 8'h3C;
    rd(3'd0, 8'h3C, "R9 data read value");
    check({15'b0, drv_ack_o}, 16'h0001, "R9 ack after data read");
    rd(3'd5, 8'h09, "R8 no new request while ack pending");
    bus_req_i = 1'b0;
    tick();
    check({15'b0, drv_ack_o}, 16'h0000, "R10 ack released on req low");
    rd(3'd5, 8'h08, "R10 flags clear");
    bus_data_i = 8'h66;
    rd(3'd0, 8'h66, "R9 read without request");
    check({15'b0, drv_ack_o}, 16'h0000, "R9 no ack without request");

    // R11 DMA off clears flags
    bus_req_i = 1'b1;
    tick();
    rd(3'd5, 8'h48, "R11 request pending before off");
    wr(3'd2, 8'h00);
    bus_req_i = 1'b0;
    tick();
    rd(3'd5, 8'h08, "R11 flags cleared");
    tick();
    tick();

    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12: got %0d pending reads expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule